// File: doc/BRIEF.md
# Debug Trigger CSR Bank

This block keeps the configuration of a small number of hardware debug triggers, two by default. Software reaches them through a select register and a window of data registers. The select register picks one trigger. The three data registers then show that trigger's control word, its compare value and an auxiliary word. A read-only capability register reports which trigger kinds the bank accepts. Every control write first passes through a legalisation stage. That stage keeps only the fields the hardware implements, forces the others to zero and drops kinds or size codes it cannot honour, so a read-back shows what was actually stored.

The port is a plain CSR port: address, write enable, write data and read data. A mode input selects whether the register layout is the 32-bit or the 64-bit one. Each trigger's stored control word and compare value are exported to an external match unit. Each trigger also gives a one-cycle pulse when either of those values really changes, so the match unit can reload. Matching itself, exception raising and debug-mode entry live elsewhere.

Address map (the `csr_addr` input):

| `csr_addr` | Register |
|---|---|
| 0 | select |
| 1 | control (data 1) |
| 2 | compare (data 2) |
| 3 | auxiliary (data 3) |
| 4 | capability |
| 5 to 7 | unused: reads return zero, writes are ignored |

Top module: `dbg_trig_bank`

## Requirements
- R1: After reset, select reads 0. Every trigger's control word holds kind 2 in the kind field of the current layout, with every other bit zero. Compare and auxiliary read zero, and no change pulse is high.
- R2: A write to select (address 0) takes effect only if the full written value is below `NUM_TRIG`. Any larger value leaves the selection unchanged.
- R3: The kind field sits at bits 31:28 in 32-bit mode (`mode64`=0) and at bits 63:60 in 64-bit mode. The debug-only bit just below it (bit 27 or bit 59) always reads zero.
- R4: A control write (address 1) is accepted only when the written kind is 2 or 6. For any other kind the stored control word is left unchanged.
- R5: Of the written control value, only bits 0 to 4 and bit 6 are kept (load, store, execute, U, S, M). Every other field (match, chain, action, timing, select, hit) stores as zero.
- R6: For kind 2, the size code is bits 17:16. In 64-bit mode only, bits 22:21 are added as its upper two bits. A legal code is stored in those same bits.
- R7: Size codes 0, 1, 2, 3 and 5 are legal. Code 4 and codes 6 to 15 store a size of zero.
- R8: For kind 6, the size code is bits 19:16, and the VU and VS enables at bits 23 and 24 are also kept. Kind 2 stores bits 23 and 24 as zero.
- R9: A compare write (address 2) stores the whole value in 64-bit mode and the low 32 bits, zero-extended, in 32-bit mode. Auxiliary writes (address 3) are ignored, and the auxiliary register reads zero.
- R10: The capability register (address 4) always reads 0x44. Addresses 5 to 7 read zero. All reads are combinational and return the selected trigger's registers in the same cycle as the address.
- R11: `trig_cfg_chg[i]` is high for exactly the one cycle after a write that changed trigger i's control or compare value. It stays low after a write that leaves the stored value unchanged.
- R12: `trig_ctrl` and `trig_cmp` carry each trigger's stored control and compare values, 64 bits per trigger, with trigger i in slice [64*i +: 64].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 selects the 64-bit layout, 0 the 32-bit layout |
| csr_addr | input | 3 | Register address |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Combinational read data |
| trig_ctrl | output | 64*NUM_TRIG | Stored control word of each trigger |
| trig_cmp | output | 64*NUM_TRIG | Stored compare value of each trigger |
| trig_cfg_chg | output | NUM_TRIG | One-cycle pulse per trigger on a real change |

## Verification
A write and a read of the same register can fall in the same cycle. So can a new write and the change pulse left by the previous write. The bench reads a data register in the cycle of the write and expects the old value, then the new value after the edge. It also issues back-to-back control writes. Between them, the pulse of the first must be high and must clear after a second write that stores the same value. Select writes mixed with data writes show that the pulse lands on the trigger selected at the time of the write.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int DW = 64;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_SEL  = 3'd0;
  localparam logic [AW-1:0] A_CTRL = 3'd1;
  localparam logic [AW-1:0] A_CMP  = 3'd2;
  localparam logic [AW-1:0] A_AUX  = 3'd3;
  localparam logic [AW-1:0] A_CAP  = 3'd4;

  localparam logic [3:0] KIND_MC  = 4'd2;
  localparam logic [3:0] KIND_MC6 = 4'd6;

  localparam logic [DW-1:0] CAP_VALUE = (DW'(1) << KIND_MC) | (DW'(1) << KIND_MC6);

  function automatic logic [DW-1:0] reset_ctrl(input logic m64);
    logic [DW-1:0] v;
    v = '0;
    if (m64) v[63:60] = KIND_MC;
    else     v[31:28] = KIND_MC;
    return v;
  endfunction
endpackage

// File: rtl/dbg_trig_legalize.sv
module dbg_trig_legalize
  import dbg_trig_pkg::*;
(
  input  logic [DW-1:0] wdata,
  input  logic          m64,
  output logic          ok,
  output logic [DW-1:0] ctrl
);
  logic [3:0] kind;
  logic [3:0] code;
  logic       is6;
  logic       size_ok;

  always_comb begin
    kind    = m64 ? wdata[63:60] : wdata[31:28];
    ok      = (kind == KIND_MC) || (kind == KIND_MC6);
    is6     = (kind == KIND_MC6);
    code    = is6 ? wdata[19:16] : {(m64 ? wdata[22:21] : 2'b00), wdata[17:16]};
    size_ok = (code <= 4'd3) || (code == 4'd5);
    ctrl      = '0;
    ctrl[4:0] = wdata[4:0];
    ctrl[6]   = wdata[6];
    if (is6) ctrl[24:23] = wdata[24:23];
    if (size_ok) begin
      if (is6) ctrl[19:16] = code;
      else begin
        ctrl[17:16] = code[1:0];
        if (m64) ctrl[22:21] = code[3:2];
      end
    end
    if (m64) ctrl[63:60] = kind;
    else     ctrl[31:28] = kind;
  end
endmodule

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
  import dbg_trig_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          m64,
  input  logic          wr_ctrl,
  input  logic          wr_cmp,
  input  logic [DW-1:0] ctrl_new,
  input  logic [DW-1:0] cmp_new,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] cmp_q,
  output logic          chg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= reset_ctrl(m64);
      cmp_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= (wr_ctrl && (ctrl_new != ctrl_q)) || (wr_cmp && (cmp_new != cmp_q));
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_cmp)  cmp_q  <= cmp_new;
    end
  end
endmodule

// File: rtl/dbg_trig_rdmux.sv
module dbg_trig_rdmux
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int SEL_W    = 1
) (
  input  logic [AW-1:0]          addr,
  input  logic [SEL_W-1:0]       sel,
  input  logic [NUM_TRIG*DW-1:0] ctrl_flat,
  input  logic [NUM_TRIG*DW-1:0] cmp_flat,
  output logic [DW-1:0]          rdata
);
  always_comb begin
    case (addr)
      A_SEL:   rdata = DW'(sel);
      A_CTRL:  rdata = ctrl_flat[int'(sel)*DW +: DW];
      A_CMP:   rdata = cmp_flat[int'(sel)*DW +: DW];
      A_CAP:   rdata = CAP_VALUE;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode64,
  input  logic [2:0]             csr_addr,
  input  logic                   csr_we,
  input  logic [63:0]            csr_wdata,
  output logic [63:0]            csr_rdata,
  output logic [NUM_TRIG*64-1:0] trig_ctrl,
  output logic [NUM_TRIG*64-1:0] trig_cmp,
  output logic [NUM_TRIG-1:0]    trig_cfg_chg
);
  localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [SEL_W-1:0] sel_q;
  logic             leg_ok;
  logic [DW-1:0]    leg_ctrl;
  logic [DW-1:0]    cmp_new;
  logic             wr_ctrl_any;
  logic             wr_cmp_any;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (csr_we && csr_addr == A_SEL && csr_wdata < DW'(NUM_TRIG))
      sel_q <= csr_wdata[SEL_W-1:0];
  end

  dbg_trig_legalize leg_i (
    .wdata (csr_wdata),
    .m64   (mode64),
    .ok    (leg_ok),
    .ctrl  (leg_ctrl)
  );

  assign cmp_new     = mode64 ? csr_wdata : {32'b0, csr_wdata[31:0]};
  assign wr_ctrl_any = csr_we && (csr_addr == A_CTRL) && leg_ok;
  assign wr_cmp_any  = csr_we && (csr_addr == A_CMP);

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
    dbg_trig_slot slot_i (
      .clk      (clk),
      .rst      (rst),
      .m64      (mode64),
      .wr_ctrl  (wr_ctrl_any && (int'(sel_q) == i)),
      .wr_cmp   (wr_cmp_any && (int'(sel_q) == i)),
      .ctrl_new (leg_ctrl),
      .cmp_new  (cmp_new),
      .ctrl_q   (trig_ctrl[i*DW +: DW]),
      .cmp_q    (trig_cmp[i*DW +: DW]),
      .chg_q    (trig_cfg_chg[i])
    );
  end

  dbg_trig_rdmux #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) rd_i (
    .addr      (csr_addr),
    .sel       (sel_q),
    .ctrl_flat (trig_ctrl),
    .cmp_flat  (trig_cmp),
    .rdata     (csr_rdata)
  );
endmodule

// File: rtl/dbg_trig_bank_chk.sv
module dbg_trig_bank_chk #(
  parameter int NUM_TRIG = 2,
  parameter int SEL_W    = 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   mode64,
  input logic [2:0]             csr_addr,
  input logic                   csr_we,
  input logic [63:0]            csr_wdata,
  input logic [63:0]            csr_rdata,
  input logic [NUM_TRIG*64-1:0] trig_ctrl,
  input logic [NUM_TRIG-1:0]    trig_cfg_chg,
  input logic [SEL_W-1:0]       sel_q
);
  logic [3:0] wkind;
  assign wkind = mode64 ? csr_wdata[63:60] : csr_wdata[31:28];

  assert_sel_range_R2: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_addr == 3'd0 && csr_wdata >= 64'(NUM_TRIG)) |=> $stable(sel_q));

  assert_bad_kind_R4: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_addr == 3'd1 && wkind != 4'd2 && wkind != 4'd6) |=> $stable(trig_ctrl));

  assert_cap_value_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == 3'd4) |-> (csr_rdata == 64'h44));

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(trig_cfg_chg) <= 1);

  assert_pulse_needs_write_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(csr_we) |-> (trig_cfg_chg == '0));

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_dm
    assert_dbg_bit_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (mode64 ? trig_ctrl[i*64+59] : trig_ctrl[i*64+27]) == 1'b0);
  end
endmodule

bind dbg_trig_bank dbg_trig_bank_chk #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .mode64       (mode64),
  .csr_addr     (csr_addr),
  .csr_we       (csr_we),
  .csr_wdata    (csr_wdata),
  .csr_rdata    (csr_rdata),
  .trig_ctrl    (trig_ctrl),
  .trig_cfg_chg (trig_cfg_chg),
  .sel_q        (sel_q)
);

// File: tb/dbg_trig_bank_tb_top.sv
module dbg_trig_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           mode64 = 1'b1;
  logic [2:0]     csr_addr = '0;
  logic           csr_we = 1'b0;
  logic [63:0]    csr_wdata = '0;
  logic [63:0]    csr_rdata;
  logic [NT*64-1:0] trig_ctrl;
  logic [NT*64-1:0] trig_cmp;
  logic [NT-1:0]  trig_cfg_chg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_bank #(.NUM_TRIG(NT)) dut_i (
    .clk(clk), .rst(rst), .mode64(mode64), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trig_ctrl(trig_ctrl),
    .trig_cmp(trig_cmp), .trig_cfg_chg(trig_cfg_chg)
  );

  // {written control value, expected read-back}, 64-bit layout, trigger 0
  localparam logic [127:0] VEC [8] = '{
    {64'h2000_0000_07FF_FFFF, 64'h2000_0000_0000_005F},
    {64'h2000_0000_0021_000C, 64'h2000_0000_0021_000C},
    {64'h2800_0000_0002_1841, 64'h2000_0000_0002_0041},
    {64'h6000_0000_01C5_0007, 64'h6000_0000_0185_0007},
    {64'h6000_0000_0004_0018, 64'h6000_0000_0000_0018},
    {64'h3000_0000_0000_00FF, 64'h6000_0000_0000_0018},
    {64'h2000_0000_0180_0010, 64'h2000_0000_0000_0010},
    {64'h0000_0000_0000_0000, 64'h2000_0000_0000_0010}
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] v;
    do_reset();
    // R1 reset state in 64-bit layout
    rd(3'd0, v); check(v, 64'h0, "R1 select");
    rd(3'd1, v); check(v, 64'h2000_0000_0000_0000, "R1 ctrl");
    rd(3'd2, v); check(v, 64'h0, "R1 cmp");
    rd(3'd3, v); check(v, 64'h0, "R1 aux");
    check(64'(trig_cfg_chg), 64'h0, "R1 pulses");
    rd(3'd4, v); check(v, 64'h44, "R10 capability");
    rd(3'd6, v); check(v, 64'h0, "R10 unused address");

    // legalisation table: R4 R5 R6 R7 R8
    for (int k = 0; k < 8; k++) begin
      wr(3'd1, VEC[k][127:64]);
      rd(3'd1, v);
      check(v, VEC[k][63:0], $sformatf("R5 R6 R7 R8 R4 vector %0d", k));
    end
    // R12 export of trigger 0
    check(trig_ctrl[63:0], 64'h2000_0000_0000_0010, "R12 ctrl export");

    // R11 same value: no pulse; new value: one-cycle pulse
    wr(3'd1, 64'h2000_0000_0000_0010);
    check(64'(trig_cfg_chg), 64'h0, "R11 no change");
    wr(3'd1, 64'h2000_0000_0000_0044);
    check(64'(trig_cfg_chg), 64'h1, "R11 pulse");
    @(negedge clk);
    check(64'(trig_cfg_chg), 64'h0, "R11 pulse width");

    // same-cycle write and read: old value before the edge
    @(negedge clk);
    csr_addr = 3'd1; csr_wdata = 64'h2000_0000_0000_0045; csr_we = 1'b1;
    #1; check(csr_rdata, 64'h2000_0000_0000_0044, "R10 read during write");
    @(negedge clk);
    csr_wdata = 64'h2000_0000_0000_0045;
    #1; check(csr_rdata, 64'h2000_0000_0000_0045, "R10 read after write");
    check(64'(trig_cfg_chg), 64'h1, "R11 first of back-to-back");
    @(negedge clk);
    csr_we = 1'b0;
    check(64'(trig_cfg_chg), 64'h0, "R11 repeat write no pulse");

    // R2 select
    wr(3'd0, 64'd1); rd(3'd0, v); check(v, 64'd1, "R2 select 1");
    wr(3'd0, 64'd2); rd(3'd0, v); check(v, 64'd1, "R2 select 2 ignored");
    wr(3'd0, 64'h1_0000_0000); rd(3'd0, v); check(v, 64'd1, "R2 large ignored");

    // R9 compare and aux on trigger 1
    wr(3'd2, 64'hDEAD_BEEF_1234_5678);
    check(64'(trig_cfg_chg), 64'h2, "R11 pulse on trigger 1");
    rd(3'd2, v); check(v, 64'hDEAD_BEEF_1234_5678, "R9 cmp 64");
    check(trig_cmp[127:64], 64'hDEAD_BEEF_1234_5678, "R12 cmp export");
    check(trig_cmp[63:0], 64'h0, "R12 trigger 0 cmp untouched");
    wr(3'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(3'd3, v); check(v, 64'h0, "R9 aux ignored");
    wr(3'd1, 64'h6000_0000_0005_0008);
    check(trig_ctrl[127:64], 64'h6000_0000_0005_0008, "R12 trigger 1 ctrl");
    check(trig_ctrl[63:0], 64'h2000_0000_0000_0045, "R12 trigger 0 ctrl kept");

    // 32-bit layout
    mode64 = 1'b0;
    do_reset();
    rd(3'd1, v); check(v, 64'h2000_0000, "R1 R3 reset ctrl 32");
    wr(3'd1, 64'h6805_0003); rd(3'd1, v); check(v, 64'h6005_0003, "R3 dbg bit 32");
    wr(3'd1, 64'hFFFF_FFFF_2061_0004); rd(3'd1, v); check(v, 64'h2001_0004, "R6 size hi ignored 32");
    wr(3'd1, 64'h6000_0000_0000_0001); rd(3'd1, v); check(v, 64'h2001_0004, "R3 R4 kind from low word");
    wr(3'd2, 64'hAAAA_BBBB_CCCC_DDDD); rd(3'd2, v); check(v, 64'hCCCC_DDDD, "R9 cmp 32");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule